// File: doc/BRIEF.md
# Register-Pair Word Arithmetic Unit

This unit adds 16-bit operations to an 8-bit processor datapath. A word register is formed from two byte registers, the low byte from the accumulator and the high byte from the Y index. The second operand is a 16-bit word that the surrounding core has already gathered from two adjacent direct-page bytes. The unit supports seven operations: load the pair from memory, store the pair to memory, add, subtract, compare, increment the memory word and decrement the memory word. For each one it returns the result word, a write strobe for the register pair or for the memory word, and the updated status flags.

The core presents one operation per cycle with `op_valid`. The result, the strobes and the flags appear one clock later. A flag that the operation does not touch is copied from `flags_in`, so the core can write `flags_out` back to its status register every time. The core still does the two byte-wide memory accesses and picks the direct-page base.

Top module: `word_pair_alu`

## Requirements
- R1: Op code 0 (load) gives result = `mem_word` and asserts `pair_we`. N = result bit 15 and Z = (result == 0). V, H and C pass through from `flags_in`. The flag vector is {N,V,H,Z,C} at bits 4..0.
- R2: Op code 1 (store) gives result = {`reg_hi`,`reg_lo`} and asserts `mem_we`. All five flags pass through unchanged.
- R3: Op code 2 (add) gives result = pair + `mem_word` modulo 2^16 and asserts `pair_we`. The incoming C does not take part. C = carry out of bit 15, H = carry out of bit 11 and V = signed overflow. N and Z follow R1.
- R4: Op code 3 (subtract) gives result = pair − `mem_word` modulo 2^16 and asserts `pair_we`. The incoming C does not take part. C = 1 when no borrow occurs (pair ≥ mem). H = 1 when the low 12 bits of the pair are ≥ the low 12 bits of mem. V = signed overflow. N and Z follow R1.
- R5: Op code 4 (compare) computes the same difference as R4 and places it on `result`. N, Z and C follow R4, V and H pass through, and neither write strobe is asserted.
- R6: Op code 5 (increment) and op code 6 (decrement) give result = `mem_word` ± 1, wrapping between 0xFFFF and 0x0000, and assert `mem_we`. N and Z follow R1, and V, H and C pass through.
- R7: All outputs register one clock after an accepted operation, and `res_valid` is high for exactly that cycle. No write strobe is ever asserted without `res_valid`, and the two strobes are never high together.
- R8: Op code 7 (reserved) gives result = 0 with no write strobe, and all flags pass through.
- R9: After a synchronous active-low reset, `res_valid`, both strobes, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 3 | Operation select (0 load, 1 store, 2 add, 3 sub, 4 compare, 5 inc, 6 dec) |
| reg_lo | input | 8 | Accumulator byte, pair bits 7:0 |
| reg_hi | input | 8 | Y index byte, pair bits 15:8 |
| mem_word | input | 16 | Word assembled from two direct-page bytes |
| flags_in | input | 5 | Current {N,V,H,Z,C} |
| res_valid | output | 1 | Result and strobes valid |
| result | output | 16 | Result word |
| pair_we | output | 1 | Write result into the register pair |
| mem_we | output | 1 | Write result to the memory word |
| flags_out | output | 5 | Updated {N,V,H,Z,C} |

## Verification
The bench targets the boundaries of the carry chain. These are 0xFFFF + 1, which must give zero with C, H and Z set; 0x7FFF + 1, which must raise V; and 0 − 1, which must clear C and H. A design that fed the incoming carry into the adder, or that took the half carry from bit 7 instead of bit 11, would show wrong sums or a wrong H on these cases. Increment and decrement at the wrap points test that only N and Z change. The bench also checks that compare and the reserved code leave both strobes low, and that store and the reserved code keep every flag. A design that wrote the pair on compare, or that cleared V on a load, would fail these checks.

// File: rtl/wpa_pkg.sv
// Shared types for the register-pair word unit.
// Assumes a five-bit flag vector ordered {N,V,H,Z,C} from bit 4 down to 0.
package wpa_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_CMP   = 3'd4,
        OP_INC   = 3'd5,
        OP_DEC   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    localparam int FLAG_W = 5;
    localparam int FL_N   = 4;
    localparam int FL_V   = 3;
    localparam int FL_H   = 2;
    localparam int FL_Z   = 1;
    localparam int FL_C   = 0;
endpackage

// File: rtl/wpa_adder.sv
// Split carry-chain adder: a + b + cin over W bits.
// Reports the carry out of the top bit, the carry out of bit HB-1 (half carry)
// and the two's-complement overflow. Assumes 0 < HB < W.
module wpa_adder #(
    parameter int W  = 16,
    parameter int HB = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcarry,
    output logic         ovf
);
    localparam int UW = W - HB;

    logic [HB:0] low_part;
    logic [UW:0] high_part;

    // Lower segment up to the half-carry boundary.
    always_comb low_part = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};

    // Upper segment fed by the lower segment's carry.
    always_comb high_part = {1'b0, a[W-1:HB]} + {1'b0, b[W-1:HB]} + {{UW{1'b0}}, low_part[HB]};

    // Assemble outputs and derive signed overflow.
    always_comb begin
        sum    = {high_part[UW-1:0], low_part[HB-1:0]};
        cout   = high_part[UW];
        hcarry = low_part[HB];
        ovf    = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/wpa_flag_sel.sv
// Per-operation flag update: each flag takes the freshly computed value when
// the operation affects it, otherwise it keeps the incoming value.
// Assumes the flag order of wpa_pkg.
module wpa_flag_sel
    import wpa_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e               op,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [W-1:0]      res,
    input  logic              cout,
    input  logic              hcarry,
    input  logic              ovf,
    output logic [FLAG_W-1:0] flags_out
);
    logic [FLAG_W-1:0] fresh;
    logic [FLAG_W-1:0] upd_mask;

    // Freshly computed flag values for the current result.
    always_comb begin
        fresh       = '0;
        fresh[FL_N] = res[W-1];
        fresh[FL_V] = ovf;
        fresh[FL_H] = hcarry;
        fresh[FL_Z] = (res == '0);
        fresh[FL_C] = cout;
    end

    // Which flags each operation is allowed to change.
    always_comb begin
        case (op)
            OP_LOAD, OP_INC, OP_DEC: upd_mask = 5'b10010;
            OP_ADD, OP_SUB:          upd_mask = 5'b11111;
            OP_CMP:                  upd_mask = 5'b10011;
            default:                 upd_mask = 5'b00000;
        endcase
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        assign flags_out[i] = upd_mask[i] ? fresh[i] : flags_in[i];
    end
endmodule

// File: rtl/word_pair_alu.sv
// Word operations on the {Y,A} register pair against a direct-page word.
// One shared adder serves add, subtract, compare, increment and decrement;
// outputs are registered one cycle after op_valid. Assumes the caller performs
// both byte accesses and writes flags_out back unconditionally.
module word_pair_alu
    import wpa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [BYTE_W-1:0]   reg_lo,
    input  logic [BYTE_W-1:0]   reg_hi,
    input  logic [2*BYTE_W-1:0] mem_word,
    input  logic [4:0]          flags_in,
    output logic                res_valid,
    output logic [2*BYTE_W-1:0] result,
    output logic                pair_we,
    output logic                mem_we,
    output logic [4:0]          flags_out
);
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int HALF_BIT = WORD_W - 4;

    op_e               op;
    op_e               op_q;
    logic [WORD_W-1:0] pair;
    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;
    logic              cin;
    logic [WORD_W-1:0] sum;
    logic              cout;
    logic              hcarry;
    logic              ovf;
    logic [WORD_W-1:0] result_d;
    logic              pair_we_d;
    logic              mem_we_d;
    logic [FLAG_W-1:0] flags_d;

    assign op   = op_e'(op_code);
    assign pair = {reg_hi, reg_lo};

    // Steer adder operands: subtract uses inverted mem with carry-in 1.
    always_comb begin
        opa = pair;
        opb = mem_word;
        cin = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin opb = ~mem_word; cin = 1'b1; end
            OP_INC:         begin opa = mem_word; opb = '0; cin = 1'b1; end
            OP_DEC:         begin opa = mem_word; opb = '1; end
            default:        ;
        endcase
    end

    wpa_adder #(.W(WORD_W), .HB(HALF_BIT)) u_adder (
        .a(opa), .b(opb), .cin(cin),
        .sum(sum), .cout(cout), .hcarry(hcarry), .ovf(ovf)
    );

    // Choose the result word and its destination.
    always_comb begin
        result_d  = '0;
        pair_we_d = 1'b0;
        mem_we_d  = 1'b0;
        case (op)
            OP_LOAD:        begin result_d = mem_word; pair_we_d = 1'b1; end
            OP_STORE:       begin result_d = pair;     mem_we_d  = 1'b1; end
            OP_ADD, OP_SUB: begin result_d = sum;      pair_we_d = 1'b1; end
            OP_CMP:         result_d = sum;
            OP_INC, OP_DEC: begin result_d = sum;      mem_we_d  = 1'b1; end
            default:        ;
        endcase
    end

    wpa_flag_sel #(.W(WORD_W)) u_flags (
        .op(op), .flags_in(flags_in), .res(result_d),
        .cout(cout), .hcarry(hcarry), .ovf(ovf), .flags_out(flags_d)
    );

    // Output register stage; strobes pulse only with an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            pair_we   <= 1'b0;
            mem_we    <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            op_q      <= OP_RSVD;
        end else begin
            res_valid <= op_valid;
            pair_we   <= op_valid && pair_we_d;
            mem_we    <= op_valid && mem_we_d;
            if (op_valid) begin
                result    <= result_d;
                flags_out <= flags_d;
                op_q      <= op;
            end
        end
    end

    p_load_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op == OP_LOAD |=> result == $past(mem_word) && pair_we);

    p_store_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op == OP_STORE |=> flags_out == $past(flags_in) && mem_we);

    p_cmp_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && op_q == OP_CMP |-> !pair_we && !mem_we);

    p_incdec_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op == OP_INC || op == OP_DEC)
        |=> flags_out[FL_V:FL_H] == $past(flags_in[FL_V:FL_H])
            && flags_out[FL_C] == $past(flags_in[FL_C]));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_we_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pair_we, mem_we}));

    p_we_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we || mem_we) |-> res_valid);
endmodule

// File: tb/word_pair_alu_test.sv
module word_pair_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  reg_lo = 8'd0;
    logic [7:0]  reg_hi = 8'd0;
    logic [15:0] mem_word = 16'd0;
    logic [4:0]  flags_in = 5'd0;
    logic        res_valid;
    logic [15:0] result;
    logic        pair_we;
    logic        mem_we;
    logic [4:0]  flags_out;

    int checks = 0;
    int errors = 0;

    word_pair_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .reg_lo(reg_lo), .reg_hi(reg_hi), .mem_word(mem_word), .flags_in(flags_in),
        .res_valid(res_valid), .result(result), .pair_we(pair_we),
        .mem_we(mem_we), .flags_out(flags_out)
    );

    always #5 clk = ~clk;

    // Expected {valid, result, pair_we, mem_we, flags} from the requirements.
    function automatic logic [23:0] model(input logic [2:0] op, input logic [15:0] pr,
                                          input logic [15:0] m, input logic [4:0] fi);
        logic [15:0] r;
        logic [16:0] s;
        logic pw, mw;
        logic [4:0] f;
        r = 16'd0; pw = 1'b0; mw = 1'b0; f = fi;
        case (op)
            3'd0: begin r = m; pw = 1'b1; end
            3'd1: begin r = pr; mw = 1'b1; end
            3'd2: begin
                s = {1'b0, pr} + {1'b0, m};
                r = s[15:0]; pw = 1'b1;
                f[3] = (pr[15] == m[15]) && (r[15] != pr[15]);
                f[2] = ({1'b0, pr[11:0]} + {1'b0, m[11:0]}) > 13'h0FFF;
                f[0] = s[16];
            end
            3'd3, 3'd4: begin
                r = pr - m;
                pw = (op == 3'd3);
                if (op == 3'd3) begin
                    f[3] = (pr[15] != m[15]) && (r[15] != pr[15]);
                    f[2] = pr[11:0] >= m[11:0];
                end
                f[0] = pr >= m;
            end
            3'd5: begin r = m + 16'd1; mw = 1'b1; end
            3'd6: begin r = m - 16'd1; mw = 1'b1; end
            default: ;
        endcase
        if (op != 3'd1 && op != 3'd7) begin
            f[4] = r[15];
            f[1] = (r == 16'd0);
        end
        return {1'b1, r, pw, mw, f};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1 load";
            3'd1: return "R2 store";
            3'd2: return "R3 add";
            3'd3: return "R4 sub";
            3'd4: return "R5 compare";
            3'd5: return "R6 inc";
            3'd6: return "R6 dec";
            default: return "R8 reserved";
        endcase
    endfunction

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Present one operation, then sample one cycle later away from the edge (R7).
    task automatic run_op(input logic [2:0] op, input logic [15:0] pr,
                          input logic [15:0] m, input logic [4:0] fi);
        @(negedge clk);
        op_valid = 1'b1; op_code = op;
        reg_hi = pr[15:8]; reg_lo = pr[7:0]; mem_word = m; flags_in = fi;
        @(negedge clk);
        op_valid = 1'b0;
        check(tag_of(op), {res_valid, result, pair_we, mem_we, flags_out}, model(op, pr, m, fi));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset", {res_valid, result, pair_we, mem_we, flags_out}, 24'd0);
        rst_n = 1'b1;

        // Directed corners
        run_op(3'd2, 16'hFFFF, 16'h0001, 5'b00001); // R3 wrap to zero, C,H,Z
        run_op(3'd2, 16'h7FFF, 16'h0001, 5'b00000); // R3 signed overflow
        run_op(3'd2, 16'h0F00, 16'h0100, 5'b00001); // R3 half carry, carry-in ignored
        run_op(3'd3, 16'h0000, 16'h0001, 5'b00000); // R4 borrow: C=0,H=0
        run_op(3'd3, 16'h8000, 16'h0001, 5'b00000); // R4 overflow
        run_op(3'd3, 16'h1234, 16'h1234, 5'b00000); // R4 zero
        run_op(3'd4, 16'h4000, 16'h4000, 5'b01100); // R5 equal, V H kept
        run_op(3'd4, 16'h0001, 16'h0002, 5'b01000); // R5 below
        run_op(3'd5, 16'h0000, 16'hFFFF, 5'b01101); // R6 inc wrap
        run_op(3'd6, 16'h0000, 16'h0000, 5'b01100); // R6 dec wrap
        run_op(3'd0, 16'h0000, 16'h0000, 5'b01101); // R1 load zero
        run_op(3'd0, 16'h0000, 16'h8001, 5'b00000); // R1 load negative
        run_op(3'd1, 16'hA55A, 16'h0000, 5'b11111); // R2 store keeps all
        run_op(3'd7, 16'hFFFF, 16'hFFFF, 5'b10101); // R8 reserved

        // R7 idle cycle: no valid, no strobes
        @(negedge clk);
        check("R7 idle", {22'd0, res_valid, pair_we | mem_we}, 24'd0);

        // Constrained random mix
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  rop;
            logic [15:0] rpr, rm;
            logic [4:0]  rfi;
            rop = 3'($urandom_range(0, 7));
            rpr = 16'($urandom);
            rm  = 16'($urandom);
            rfi = 5'($urandom);
            if (i % 8 == 0) rm = 16'hFFFF;
            if (i % 8 == 1) rpr = rm;
            run_op(rop, rpr, rm, rfi);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule